// File: doc/BRIEF.md
# Mode Register Write Command Sequencer

This block sits on the controller side of a low-power DDR memory interface. It takes one request at a time to program a configuration register in the memory device. Each request carries an 8-bit register address, an 8-bit value and a flag that turns it into a device reset. The block turns the request into the command sequence the device expects. When the controller reports that any bank is still open, the block first sends a precharge-all command and waits out the precharge time. It then sends the register write command and holds the command bus at no-operation until the write period has elapsed.

The command/address bus is double data rate. The block presents both halves of each bus cycle in parallel: a 10-bit word for the rising edge and a 10-bit word for the falling edge. A physical layer serializes them. Chip select is active low and goes low only in command cycles. A reset request sends the write to a fixed reset register address with zero data. It then holds no-operation for the longer initialisation period. The request side uses a valid/ready handshake. A single-cycle done pulse marks the end of each sequence.

Top module: `mrw_seq`

## Requirements
- R1: While reset is asserted and afterwards until a request arrives, req_ready is 1, cs_n is 1, done is 0 and both CA words are all zero.
- R2: req_ready is 1 only when the sequencer is idle. From the cycle after a request is accepted (req_valid and req_ready both high at a clock edge), req_ready stays 0 until the cycle in which done is high.
- R3: When banks_open is 0 at acceptance, the write command appears in the very next cycle.
- R4: When banks_open is 1 at acceptance, the next cycle carries the precharge-all command: cs_n low, rise word PREA_RISE (default 0x01B), fall word PREA_FALL (default 0x000). T_RP no-operation cycles (default 3) follow, and the write command comes after them.
- R5: In the write command cycle cs_n is 0. Rise word bits 3..0 are 0000 and rise word bits 9..4 hold address bits 7..2.
- R6: In the write command cycle, fall word bits 1..0 hold address bits 1..0 and fall word bits 9..2 hold data bits 7..0.
- R7: Every cycle that is not a command cycle is a no-operation: cs_n is 1 and both CA words are zero. Chip select is never low in two cycles in a row.
- R8: After an ordinary write, exactly T_MRW-1 no-operation cycles follow (default T_MRW = 5). The sequencer is idle again in the cycle after them, so two write commands are always at least T_MRW cycles apart.
- R9: A request with req_reset set writes to address RST_ADDR (default 0x3F) with data 0x00, whatever req_addr and req_data hold. T_INIT-1 no-operation cycles follow (default T_INIT = 20) before done.
- R10: done is a single-cycle pulse. It is raised in the first idle cycle after the no-operation window, and req_ready is 1 in that cycle.
- R11: Address, data, reset flag and banks_open are captured at acceptance. Changes on those inputs, and a held req_valid, have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | 8 | Target register address |
| req_data | input | 8 | Value to write |
| req_reset | input | 1 | Issue a device reset write instead |
| banks_open | input | 1 | At least one bank is open in the device |
| cs_n | output | 1 | Chip select, active low |
| ca_rise | output | 10 | CA bus word for the rising clock edge |
| ca_fall | output | 10 | CA bus word for the falling clock edge |
| done | output | 1 | One-cycle pulse when the sequence finishes |

## Verification
The assertions assume that banks_open matters only in the cycle a request is accepted, and that the default PREA_RISE value has a nonzero low nibble, so it cannot be mistaken for a write. They also assume reset is held low from time zero. The stimulus changes inputs only at falling clock edges and holds reset for several cycles at the start. It raises requests only after the bench's model predicts the sequencer is idle, except in the back-to-back run. That run holds req_valid high and changes address, data, reset flag and banks_open on every cycle, so the busy-time values must be ignored.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_PRE_WAIT,
      ST_CMD,
      ST_HOLD
   } seq_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/mrw_ca_pack.sv
// Packs register address and data into the two CA words of a write command.
module mrw_ca_pack #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CA_W   = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [CA_W-1:0]   rise,
   output logic [CA_W-1:0]   fall
);

   localparam int unsigned OPC_W = 4;
   localparam int unsigned LOW_A = 2;

   if (CA_W - OPC_W != ADDR_W - LOW_A) begin : g_bad_rise
      $error("rise word cannot hold the upper address bits");
   end
   if (CA_W - LOW_A != DATA_W) begin : g_bad_fall
      $error("fall word cannot hold the data byte");
   end

   for (genvar i = 0; i < OPC_W; i++) begin : g_opc
      assign rise[i] = 1'b0;
   end
   for (genvar i = OPC_W; i < CA_W; i++) begin : g_hi_addr
      assign rise[i] = addr[i - OPC_W + LOW_A];
   end
   for (genvar i = 0; i < LOW_A; i++) begin : g_lo_addr
      assign fall[i] = addr[i];
   end
   for (genvar i = LOW_A; i < CA_W; i++) begin : g_data
      assign fall[i] = data[i - LOW_A];
   end

endmodule

// File: rtl/mrw_hold_timer.sv
// Loadable down counter that reports when it has reached zero.
module mrw_hold_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R8: the window shrinks by exactly one each cycle it is not reloaded
   p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mrw_seq.sv
module mrw_seq #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CA_W     = 10,
   parameter int unsigned T_MRW    = 5,
   parameter int unsigned T_RP     = 3,
   parameter int unsigned T_INIT   = 20,
   parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h3F,
   parameter logic [CA_W-1:0]   PREA_RISE = 10'h01B,
   parameter logic [CA_W-1:0]   PREA_FALL = 10'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_reset,
   input  logic              banks_open,
   output logic              cs_n,
   output logic [CA_W-1:0]   ca_rise,
   output logic [CA_W-1:0]   ca_fall,
   output logic              done
);
   import mrw_pkg::*;

   localparam int unsigned MAX_WAIT = max3(T_MRW, T_RP, T_INIT);
   localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

   if (T_MRW < 2)  begin : g_bad_mrw  $error("T_MRW must be at least 2");  end
   if (T_INIT < 2) begin : g_bad_init $error("T_INIT must be at least 2"); end
   if (T_RP < 1)   begin : g_bad_rp   $error("T_RP must be at least 1");   end
   if (PREA_RISE[3:0] == 4'b0000) begin : g_bad_prea
      $error("precharge encoding collides with the write opcode");
   end

   seq_state_e        state, state_nx;
   logic [ADDR_W-1:0] addr_q, eff_addr;
   logic [DATA_W-1:0] data_q, eff_data;
   logic              rst_q, done_q;
   logic              accept, tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   logic [CA_W-1:0]   cmd_rise, cmd_fall;

   assign accept = req_valid && req_ready;

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: if (accept) state_nx = banks_open ? ST_PRE : ST_CMD;
         ST_PRE: begin
            state_nx = ST_PRE_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP - 1);
         end
         ST_PRE_WAIT: if (tmr_zero) state_nx = ST_CMD;
         ST_CMD: begin
            state_nx = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = rst_q ? CNT_W'(T_INIT - 2) : CNT_W'(T_MRW - 2);
         end
         ST_HOLD: if (tmr_zero) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         data_q <= '0;
         rst_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         state  <= state_nx;
         done_q <= (state == ST_HOLD) && tmr_zero;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            rst_q  <= req_reset;
         end
      end
   end

   mrw_hold_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   assign eff_addr = rst_q ? RST_ADDR : addr_q;
   assign eff_data = rst_q ? '0 : data_q;

   mrw_ca_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CA_W(CA_W)) u_pack (
      .addr (eff_addr),
      .data (eff_data),
      .rise (cmd_rise),
      .fall (cmd_fall)
   );

   always_comb begin
      cs_n    = 1'b1;
      ca_rise = '0;
      ca_fall = '0;
      if (state == ST_PRE) begin
         cs_n    = 1'b0;
         ca_rise = PREA_RISE;
         ca_fall = PREA_FALL;
      end else if (state == ST_CMD) begin
         cs_n    = 1'b0;
         ca_rise = cmd_rise;
         ca_fall = cmd_fall;
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign done      = done_q;

   p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !banks_open) |=> (!cs_n && ca_rise[3:0] == 4'b0000));
   p_precharge_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && banks_open) |=> (!cs_n && ca_rise == PREA_RISE && ca_fall == PREA_FALL));
   p_rise_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD) |-> (ca_rise[CA_W-1:4] == eff_addr[ADDR_W-1:2]));
   p_nop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (ca_rise == '0 && ca_fall == '0));
   p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> cs_n);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

// File: tb/sim_mrw_seq.sv
`timescale 1ns/1ps
module sim_mrw_seq;

   localparam int T_MRW  = 5;
   localparam int T_RP   = 3;
   localparam int T_INIT = 20;
   localparam logic [7:0] RST_ADDR = 8'h3F;
   localparam logic [9:0] PREA_R   = 10'h01B;
   localparam logic [9:0] PREA_F   = 10'h000;

   typedef struct packed {
      logic       cs_n;
      logic [9:0] rise;
      logic [9:0] fall;
      logic       ready;
      logic       done;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic       req_reset = 1'b0;
   logic       banks_open = 1'b0;
   logic       cs_n, done;
   logic [9:0] ca_rise, ca_fall;

   exp_t  q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   string scen = "R1 reset state";
   logic  prev_ready = 1'b1;

   always #2.5 clk = ~clk;

   mrw_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_reset(req_reset),
      .banks_open(banks_open), .cs_n(cs_n), .ca_rise(ca_rise), .ca_fall(ca_fall),
      .done(done)
   );

   function automatic exp_t mk(logic c, logic [9:0] r, logic [9:0] f, logic rd, logic dn);
      exp_t e;
      e.cs_n = c; e.rise = r; e.fall = f; e.ready = rd; e.done = dn;
      return e;
   endfunction

   // Reference model: the whole expected sequence is queued at acceptance.
   task automatic push_req(logic [7:0] a, logic [7:0] d, logic open, logic rst);
      logic [7:0] ea;
      logic [7:0] ed;
      int         win;
      ea  = rst ? RST_ADDR : a;
      ed  = rst ? 8'h00 : d;
      win = rst ? T_INIT : T_MRW;
      if (open) begin
         q.push_back(mk(1'b0, PREA_R, PREA_F, 1'b0, 1'b0));
         for (int i = 0; i < T_RP; i++) q.push_back(mk(1'b1, '0, '0, 1'b0, 1'b0));
      end
      q.push_back(mk(1'b0, {ea[7:2], 4'b0000}, {ed, ea[1:0]}, 1'b0, 1'b0));
      for (int i = 0; i < win - 1; i++) q.push_back(mk(1'b1, '0, '0, 1'b0, 1'b0));
      q.push_back(mk(1'b1, '0, '0, 1'b1, 1'b1));
   endtask

   task automatic step();
      exp_t e;
      exp_t got;
      @(negedge clk);
      if (rst_n && req_valid && prev_ready) push_req(req_addr, req_data, banks_open, req_reset);
      e = (q.size() > 0) ? q.pop_front() : mk(1'b1, '0, '0, 1'b1, 1'b0);
      got = mk(cs_n, ca_rise, ca_fall, req_ready, done);
      n_chk++;
      if (got !== e) begin
         n_fail++;
         $display("FAIL %s: got cs_n=%b rise=%h fall=%h ready=%b done=%b, expected cs_n=%b rise=%h fall=%h ready=%b done=%b",
                  scen, got.cs_n, got.rise, got.fall, got.ready, got.done,
                  e.cs_n, e.rise, e.fall, e.ready, e.done);
      end
      prev_ready = e.ready;
   endtask

   task automatic send(logic [7:0] a, logic [7:0] d, logic open, logic rst);
      req_addr = a; req_data = d; banks_open = open; req_reset = rst;
      req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      // R11: scramble inputs while busy; the queued sequence must still hold
      req_addr = ~a; req_data = ~d; banks_open = ~open; req_reset = ~rst;
      while (q.size() > 0) step();
      step();
   endtask

   initial begin
      for (int i = 0; i < 3; i++) step();
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step();

      scen = "R3 R5 R6 R7 R8 R10 direct write";
      send(8'hA5, 8'h3C, 1'b0, 1'b0);
      send(8'h00, 8'hFF, 1'b0, 1'b0);
      send(8'hFF, 8'h00, 1'b0, 1'b0);

      scen = "R4 R7 R11 precharge first";
      send(8'h5A, 8'hC3, 1'b1, 1'b0);

      scen = "R9 R11 reset request";
      send(8'h12, 8'h34, 1'b0, 1'b1);
      send(8'h77, 8'h88, 1'b1, 1'b1);

      scen = "R2 R8 R10 R11 back-to-back held valid";
      req_valid = 1'b1;
      for (int i = 0; i < 60; i++) begin
         req_addr   = 8'(i * 37 + 3);
         req_data   = 8'(i * 11 + 9);
         banks_open = (i % 5) == 2;
         req_reset  = (i % 23) == 7;
         step();
      end
      req_valid = 1'b0;
      while (q.size() > 0) step();

      scen = "R1 R7 idle after traffic";
      for (int i = 0; i < 4; i++) step();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule